// File: doc/BRIEF.md
# Core Idle-State Sequencer

This block steers one processor core between its running state and four idle depths. From shallowest to deepest they are Doze, Nap, Sleep and Winkle. Each deeper depth wakes more slowly and saves more energy. Every depth is reached by climbing a ladder of six single-purpose steps, and left by walking the same ladder back down. The ladder steps, in order, are:

1. gate the execution-unit clock;
2. request a lower core frequency;
3. purge the caches and TLB, then stop answering snoops;
4. gate the core and cache clocks;
5. drop the supply to the retention voltage;
6. power-gate the core.

Doze stops on step 1, Nap on step 2, Sleep on step 5 and Winkle on step 6. The cache purge and the voltage ramp are separate units outside this block. Each one answers through a handshake input: a purge-done pulse for the purge, and a voltage-good level for the ramp. A wake event can arrive partway through an entry. When it does, the remaining entry steps are dropped, and only the steps already taken are undone, in reverse order.

Top module: `core_idle_seq`

## Requirements
- R1: After reset the core is active. All three clock gates, frequency reduction, purge request, retention voltage and power gate are off. Snoop enable is on, state_code is 0 and busy is 0.
- R2: A request with idle_depth 0 (Doze) gates only the execution-unit clock at the next edge, with state_code 1 and busy 0. A wake in that state returns the core to active at the following edge.
- R3: A request with idle_depth 1 (Nap) gates the execution-unit clock and then asserts the frequency-reduce request one cycle later, reaching state_code 2. Cache clocks and snoop enable stay on. On wake, the frequency request is released first and the execution-unit clock one cycle after that. Nap exit issues no purge and makes no voltage change.
- R4: A request with idle_depth 2 (Sleep) raises purge_req after the frequency step and holds it until purge_done is sampled high. Core and cache clocks are then gated one cycle later, and retention voltage is selected one cycle after that, reaching state_code 3.
- R5: A request with idle_depth 3 (Winkle) follows the Sleep sequence and then asserts the power gate one cycle after retention voltage, reaching state_code 4. On wake, the power gate is the first output released.
- R6: Wake from Sleep or Winkle restores nominal voltage first. The core and cache clocks stay gated until volt_good is sampled high. The remaining steps then unwind one per cycle.
- R7: A wake during an entry sequence stops it at once. The next edge undoes the most recent step taken, and any pending purge request is withdrawn.
- R8: snoop_en falls only at the edge where a purge completes. On exit it rises before state_code returns to 0.
- R9: busy is 1 exactly while an entry or exit sequence is in progress. An idle request is ignored unless the core is active with no wake in the same cycle.
- R10: state_code reports the deepest idle depth whose steps are all in place. The codes are 0 for active, 1 for Doze, 2 for Nap, 3 for Sleep and 4 for Winkle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | Request to enter the depth on idle_depth |
| idle_depth | input | 2 | 0 Doze, 1 Nap, 2 Sleep, 3 Winkle |
| wake | input | 1 | Wake event |
| purge_done | input | 1 | Cache/TLB purge finished |
| volt_good | input | 1 | Supply is at nominal voltage |
| eu_clk_gate | output | 1 | Gate execution-unit clocks |
| core_clk_gate | output | 1 | Gate full-core clocks |
| cache_clk_gate | output | 1 | Gate cache clocks |
| freq_low_req | output | 1 | Request reduced core frequency |
| purge_req | output | 1 | Request cache/TLB purge |
| volt_retention | output | 1 | 1 selects retention voltage, 0 nominal |
| pwr_gate_en | output | 1 | Power-gate the core |
| snoop_en | output | 1 | Core answers coherence snoops |
| state_code | output | 3 | Current idle depth, 0 when active |
| busy | output | 1 | Transition in progress |

## Verification
Assertions check a set of ordering rules on every cycle:

- snoop_en falls only at a completed purge;
- clocks ungate only after volt_good with nominal voltage selected;
- the power gate rises only from retention;
- an aborted entry leaves the entering phase;
- a held request leaves the chosen depth unchanged;
- the step ladder moves at most one rung per edge.

The exact cycle on which each output moves for each depth, the behaviour while a handshake stalls, and unwinding from every abort point can only be shown by the bench's scenarios. The bench runs directed and random sequences against its own step model.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;

  typedef enum logic [1:0] {
    MD_RUN   = 2'd0,
    MD_ENTER = 2'd1,
    MD_HOLD  = 2'd2,
    MD_EXIT  = 2'd3
  } seq_mode_e;

  localparam int LVL_W    = 3;
  localparam int CODE_W   = 3;
  localparam int DEPTH_W  = 2;
  localparam int TOP_STEP = 6;

  // ladder rungs
  localparam logic [LVL_W-1:0] S_EU    = 3'd1;
  localparam logic [LVL_W-1:0] S_FREQ  = 3'd2;
  localparam logic [LVL_W-1:0] S_SNOOP = 3'd3;
  localparam logic [LVL_W-1:0] S_CLK   = 3'd4;
  localparam logic [LVL_W-1:0] S_VRET  = 3'd5;
  localparam logic [LVL_W-1:0] S_PG    = 3'd6;

  function automatic logic [LVL_W-1:0] depth_to_step(input logic [DEPTH_W-1:0] d);
    case (d)
      2'd0:    return S_EU;
      2'd1:    return S_FREQ;
      2'd2:    return S_VRET;
      default: return S_PG;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] step_to_code(input logic [LVL_W-1:0] s);
    if (s >= S_PG)        return 3'd4;
    else if (s >= S_VRET) return 3'd3;
    else if (s >= S_FREQ) return 3'd2;
    else if (s >= S_EU)   return 3'd1;
    else                  return 3'd0;
  endfunction

  function automatic logic needs_purge(input logic [LVL_W-1:0] tgt);
    return tgt >= S_SNOOP;
  endfunction

endpackage

// File: rtl/idle_step_ctrl.sv
module idle_step_ctrl
  import idle_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idle_req,
  input  logic [DEPTH_W-1:0]   idle_depth,
  input  logic                 wake,
  input  logic                 purge_done,
  input  logic                 volt_good,
  output logic [LVL_W-1:0]     step,
  output logic [LVL_W-1:0]     tgt,
  output seq_mode_e            mode
);

  logic [LVL_W-1:0] step_n, tgt_n;
  seq_mode_e        mode_n;

  // named internal events
  logic req_accept;
  logic enter_ok;
  logic exit_ok;
  logic abort_ev;
  logic [LVL_W-1:0] req_tgt;

  assign req_tgt    = depth_to_step(idle_depth);
  assign req_accept = (mode == MD_RUN) && idle_req && !wake;
  assign enter_ok   = !((step == S_FREQ) && needs_purge(tgt) && !purge_done);
  assign exit_ok    = !((step == S_CLK) && !volt_good);
  assign abort_ev   = (mode == MD_ENTER) && wake;

  always_comb begin
    step_n = step;
    tgt_n  = tgt;
    mode_n = mode;
    case (mode)
      MD_RUN: begin
        if (req_accept) begin
          tgt_n  = req_tgt;
          step_n = S_EU;
          mode_n = (req_tgt == S_EU) ? MD_HOLD : MD_ENTER;
        end
      end
      MD_ENTER, MD_HOLD, MD_EXIT: begin
        if (mode == MD_ENTER && !wake) begin
          if (enter_ok) begin
            step_n = LVL_W'(step + 3'd1);
            if (LVL_W'(step + 3'd1) == tgt) mode_n = MD_HOLD;
          end
        end else if (mode == MD_EXIT || wake) begin
          if (exit_ok) begin
            step_n = LVL_W'(step - 3'd1);
            mode_n = (step == S_EU) ? MD_RUN : MD_EXIT;
          end else begin
            mode_n = MD_EXIT;
          end
        end
      end
      default: mode_n = MD_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0;
      tgt  <= '0;
      mode <= MD_RUN;
    end else begin
      step <= step_n;
      tgt  <= tgt_n;
      mode <= mode_n;
    end
  end

  // R7: an abort leaves the entering phase at the next edge
  a_r7_abort_leaves_entry: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (mode == MD_EXIT || mode == MD_RUN));

  // R9: a request outside the active state does not change the chosen depth
  a_r9_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_RUN && idle_req) |=> $stable(tgt));

  // R6: the ladder moves at most one rung per edge
  a_r6_one_rung: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (step == $past(step) || step == LVL_W'($past(step) + 3'd1)
              || step == LVL_W'($past(step) - 3'd1)));

  // R4: the purge step is not passed without purge_done
  a_r4_purge_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_ENTER && step == S_FREQ && needs_purge(tgt) && !purge_done) |=> step <= S_FREQ);

endmodule

// File: rtl/idle_out_decode.sv
module idle_out_decode
  import idle_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wake,
  input  logic                 purge_done,
  input  logic                 volt_good,
  input  logic [LVL_W-1:0]     step,
  input  logic [LVL_W-1:0]     tgt,
  input  seq_mode_e            mode,
  output logic                 eu_clk_gate,
  output logic                 core_clk_gate,
  output logic                 cache_clk_gate,
  output logic                 freq_low_req,
  output logic                 purge_req,
  output logic                 volt_retention,
  output logic                 pwr_gate_en,
  output logic                 snoop_en,
  output logic [CODE_W-1:0]    state_code,
  output logic                 busy
);

  // rung k is in place when the ladder stands at k or above
  logic [TOP_STEP:1] rung;
  for (genvar k = 1; k <= TOP_STEP; k++) begin : g_rung
    assign rung[k] = (step >= LVL_W'(k));
  end

  assign eu_clk_gate    = rung[S_EU];
  assign freq_low_req   = rung[S_FREQ];
  assign snoop_en       = !rung[S_SNOOP];
  assign core_clk_gate  = rung[S_CLK];
  assign cache_clk_gate = rung[S_CLK];
  assign volt_retention = rung[S_VRET];
  assign pwr_gate_en    = rung[S_PG];
  assign purge_req      = (mode == MD_ENTER) && (step == S_FREQ) && needs_purge(tgt);
  assign state_code     = step_to_code(step);
  assign busy           = (mode == MD_ENTER) || (mode == MD_EXIT);

  // R8: snooping stops only at a completed purge
  a_r8_snoop_off_after_purge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(snoop_en) |-> ($past(purge_req) && $past(purge_done)));

  // R6: clocks come back only after the supply is good at nominal
  a_r6_clk_after_vgood: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cache_clk_gate) |-> ($past(volt_good) && !volt_retention));

  // R5: power gating only from retention voltage
  a_r5_pg_from_ret: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_gate_en) |-> $past(volt_retention));

  // R2: a settled Doze leaves in one cycle on wake
  a_r2_doze_fast_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd1 && !busy && !freq_low_req && wake) |=> (state_code == 3'd0 && !busy && !eu_clk_gate));

  // R3: Nap keeps caches clocked and snooping
  a_r3_nap_coherent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd2 && !busy) |-> (snoop_en && !cache_clk_gate && !volt_retention));

  // R8: active is never reported without snooping
  a_r8_active_snooping: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd0 && !busy) |-> (snoop_en && !eu_clk_gate));

endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
  import idle_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        idle_req,
  input  logic [1:0]  idle_depth,
  input  logic        wake,
  input  logic        purge_done,
  input  logic        volt_good,
  output logic        eu_clk_gate,
  output logic        core_clk_gate,
  output logic        cache_clk_gate,
  output logic        freq_low_req,
  output logic        purge_req,
  output logic        volt_retention,
  output logic        pwr_gate_en,
  output logic        snoop_en,
  output logic [2:0]  state_code,
  output logic        busy
);

  logic [LVL_W-1:0] step_w;
  logic [LVL_W-1:0] tgt_w;
  seq_mode_e        mode_w;

  idle_step_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_req   (idle_req),
    .idle_depth (idle_depth),
    .wake       (wake),
    .purge_done (purge_done),
    .volt_good  (volt_good),
    .step       (step_w),
    .tgt        (tgt_w),
    .mode       (mode_w)
  );

  idle_out_decode u_dec (
    .clk            (clk),
    .rst_n          (rst_n),
    .wake           (wake),
    .purge_done     (purge_done),
    .volt_good      (volt_good),
    .step           (step_w),
    .tgt            (tgt_w),
    .mode           (mode_w),
    .eu_clk_gate    (eu_clk_gate),
    .core_clk_gate  (core_clk_gate),
    .cache_clk_gate (cache_clk_gate),
    .freq_low_req   (freq_low_req),
    .purge_req      (purge_req),
    .volt_retention (volt_retention),
    .pwr_gate_en    (pwr_gate_en),
    .snoop_en       (snoop_en),
    .state_code     (state_code),
    .busy           (busy)
  );

endmodule

// File: tb/core_idle_seq_test.sv
`timescale 1ns/1ps
module core_idle_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_req = 1'b0;
  logic [1:0] idle_depth = 2'd0;
  logic wake = 1'b0;
  logic purge_done = 1'b0;
  logic volt_good = 1'b1;
  logic eu_clk_gate, core_clk_gate, cache_clk_gate, freq_low_req, purge_req;
  logic volt_retention, pwr_gate_en, snoop_en, busy;
  logic [2:0] state_code;

  int errors = 0;
  int checks = 0;
  string cur_tag = "R1";

  // bench model of the step ladder
  int m_lvl = 0;   // rung count 0..6
  int m_ph  = 0;   // 0 active, 1 entering, 2 settled, 3 leaving
  int m_tgt = 0;

  always #2.5 clk = ~clk;

  core_idle_seq uut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_depth(idle_depth),
    .wake(wake), .purge_done(purge_done), .volt_good(volt_good),
    .eu_clk_gate(eu_clk_gate), .core_clk_gate(core_clk_gate),
    .cache_clk_gate(cache_clk_gate), .freq_low_req(freq_low_req),
    .purge_req(purge_req), .volt_retention(volt_retention),
    .pwr_gate_en(pwr_gate_en), .snoop_en(snoop_en),
    .state_code(state_code), .busy(busy)
  );

  function automatic int rungs_for(input int d);
    // Doze 1, Nap 2, Sleep 5, Winkle 6
    if (d == 0) return 1;
    if (d == 1) return 2;
    if (d == 2) return 5;
    return 6;
  endfunction

  function automatic int code_for(input int l);
    if (l == 6) return 4;
    if (l == 5) return 3;
    if (l >= 2) return 2;
    return l;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_tag, what, act, exp);
    end
  endtask

  task automatic cmp(input string what, input logic act, input bit exp);
    chk(act === exp, what, int'(act), int'(exp));
  endtask

  task automatic check_all();
    cmp("R2 eu_clk_gate", eu_clk_gate, m_lvl >= 1);
    cmp("R3 freq_low_req", freq_low_req, m_lvl >= 2);
    cmp("R8 snoop_en", snoop_en, m_lvl < 3);
    cmp("R4 core_clk_gate", core_clk_gate, m_lvl >= 4);
    cmp("R6 cache_clk_gate", cache_clk_gate, m_lvl >= 4);
    cmp("R4 volt_retention", volt_retention, m_lvl >= 5);
    cmp("R5 pwr_gate_en", pwr_gate_en, m_lvl == 6);
    cmp("R4 purge_req", purge_req, m_ph == 1 && m_lvl == 2 && m_tgt >= 5);
    cmp("R9 busy", busy, m_ph == 1 || m_ph == 3);
    chk(int'(state_code) == code_for(m_lvl), "R10 state_code", int'(state_code), code_for(m_lvl));
  endtask

  task automatic model_edge(input bit rq, input int d, input bit wk, input bit pd, input bit vg);
    bit leave;
    leave = 1'b0;
    if (m_ph == 0) begin
      if (rq && !wk) begin
        m_tgt = rungs_for(d);
        m_lvl = 1;
        m_ph = (m_tgt == 1) ? 2 : 1;
      end
    end else if (m_ph == 3 || wk) begin
      leave = 1'b1;
    end else if (m_ph == 1) begin
      if (m_lvl != 2 || pd || m_tgt < 5) begin
        m_lvl++;
        if (m_lvl == m_tgt) m_ph = 2;
      end
    end
    if (leave) begin
      if (m_lvl == 4 && !vg) m_ph = 3;
      else begin
        m_lvl--;
        m_ph = (m_lvl == 0) ? 0 : 3;
      end
    end
  endtask

  // drive at the falling edge, let the rising edge act, compare at next falling edge
  task automatic cyc(input bit rq, input int d, input bit wk, input bit pd, input bit vg);
    idle_req = rq; idle_depth = 2'(d); wake = wk; purge_done = pd; volt_good = vg;
    model_edge(rq, d, wk, pd, vg);
    @(negedge clk);
    check_all();
  endtask

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d1e5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R1 reset";
    check_all();

    // Doze
    cur_tag = "R2 doze";
    cyc(1, 0, 0, 0, 1);
    chk(state_code == 3'd1 && !busy, "R2 doze settled", int'(state_code), 1);
    cyc(0, 0, 1, 0, 1);
    chk(state_code == 3'd0 && !eu_clk_gate, "R2 one-cycle exit", int'(eu_clk_gate), 0);

    // wake in the same cycle as a request
    cur_tag = "R9 wake+req";
    cyc(1, 2, 1, 0, 1);
    chk(!eu_clk_gate && !busy, "R9 request dropped", int'(eu_clk_gate), 0);

    // Nap
    cur_tag = "R3 nap";
    cyc(1, 1, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    chk(freq_low_req && snoop_en && !cache_clk_gate && state_code == 3'd2, "R3 nap settled",
        int'(state_code), 2);
    cur_tag = "R9 held request";
    cyc(1, 3, 0, 1, 1);
    chk(state_code == 3'd2 && !busy && !pwr_gate_en, "R9 request while idle", int'(state_code), 2);
    cur_tag = "R3 nap exit";
    cyc(0, 0, 1, 0, 1);
    chk(eu_clk_gate && !freq_low_req, "R3 freq first", int'(freq_low_req), 0);
    cyc(0, 0, 0, 0, 1);
    chk(!eu_clk_gate && state_code == 3'd0, "R3 eu last", int'(eu_clk_gate), 0);

    // Sleep with a slow purge and a slow voltage ramp
    cur_tag = "R4 sleep";
    cyc(1, 2, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0, 0, 1);
      chk(purge_req && snoop_en, "R4 purge held", int'(purge_req), 1);
    end
    cyc(0, 0, 0, 1, 1);
    chk(!snoop_en && !core_clk_gate, "R8 snoop off at purge", int'(snoop_en), 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    chk(volt_retention && state_code == 3'd3 && !busy, "R4 sleep settled", int'(state_code), 3);
    cur_tag = "R6 sleep exit";
    cyc(0, 0, 1, 0, 0);
    chk(!volt_retention && cache_clk_gate, "R6 voltage first", int'(volt_retention), 0);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0, 0, 0);
      chk(cache_clk_gate && core_clk_gate, "R6 wait volt_good", int'(cache_clk_gate), 1);
    end
    cyc(0, 0, 0, 0, 1);
    chk(!cache_clk_gate && !snoop_en, "R6 clocks back", int'(cache_clk_gate), 0);
    cyc(0, 0, 0, 0, 1);
    chk(snoop_en && busy && state_code == 3'd2, "R8 snoop before active", int'(snoop_en), 1);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);

    // Winkle
    cur_tag = "R5 winkle";
    cyc(1, 3, 0, 1, 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 1);
    chk(pwr_gate_en && state_code == 3'd4 && !busy, "R5 winkle settled", int'(state_code), 4);
    cyc(0, 0, 1, 0, 1);
    chk(!pwr_gate_en && volt_retention, "R5 power gate first", int'(pwr_gate_en), 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1);
    chk(state_code == 3'd0 && !busy, "R5 back active", int'(state_code), 0);

    // abort during the purge wait
    cur_tag = "R7 abort";
    cyc(1, 2, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 1, 0, 1);
    chk(!purge_req && !freq_low_req && eu_clk_gate, "R7 unwind", int'(purge_req), 0);
    cyc(0, 0, 0, 0, 1);
    chk(state_code == 3'd0 && !busy, "R7 active", int'(state_code), 0);

    // random phase
    cur_tag = "R9 random";
    for (int n = 0; n < 4000; n++) begin
      cyc(($urandom % 4) == 0, int'($urandom % 4), ($urandom % 8) == 0,
          ($urandom % 3) == 0, ($urandom % 2) == 0);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule